// File: doc/BRIEF.md
# Four-Wide Sequential Instruction Fetch

This block feeds a superscalar front end with four consecutive 32-bit instruction words per cycle. It keeps a byte-addressed fetch pointer and, for each fetch, returns the words at the pointer and at the next three word addresses in one group. It does not use four random-access read ports. Storage is built from 128-bit lines of four words each, split into an even-line bank and an odd-line bank. Every fetch reads two neighbouring lines at once, one from each bank, and rotates the pair by the word offset inside the line. A group that starts partway through a line therefore costs no extra cycle.

Fetched groups enter a two-entry queue that the consumer drains through a valid/ready handshake, so the next group is usually ready before it is asked for. The pointer advances by 16 bytes for each group pushed. A redirect empties the queue and restarts fetching at a new address. A pointer that is not word aligned halts fetching and raises an error output until the next redirect. The backing store is loaded one line at a time through a write port. The address space wraps modulo the store size.

Top module: `wide_fetch_unit`

## Requirements
- R1: While reset is active, and after its release until the first clock edge, `out_valid_o` and `err_o` are 0. The first edge after release pushes the group at `RESET_PC`, which is 0 by default, and that group is visible after that edge.
- R2: Lane k of `out_words_o` (bits 32k+31 down to 32k, k = 0..3) holds the word at byte address `out_pc_o` + 4k. Words are 32 bits and the byte address selects a word through bits [1:0] = 0.
- R3: Bits [3:2] of the group address choose the starting word inside line L = address[4+:log2(LINES)]. When that offset is nonzero, the group takes its remaining words from line L+1. Line L+1 wraps to line 0 after the last line, and addresses above the store size alias modulo LINES*16 bytes.
- R4: While `out_ready_i` is held high and the pointer is aligned with no redirect, `out_valid_o` stays high on every cycle after the first group, so one group is delivered per cycle.
- R5: Each group that follows the previous one without a redirect has an `out_pc_o` 16 greater than that previous group.
- R6: The queue holds at most two groups. While `out_valid_o`=1 and `out_ready_i`=0, the outputs hold steady. Once the consumer resumes, groups come out in address order with none lost or repeated.
- R7: A redirect on a clock edge empties the queue, so `out_valid_o` is 0 after that edge. The group at `redirect_pc_i` is valid after the following edge, and the redirect cycle's ready does not consume a group.
- R8: When the fetch pointer has bits [1:0] nonzero, `err_o` is 1 and no group is pushed. An aligned redirect clears `err_o` after the redirect edge.
- R9: A line write with `wr_en_i`=1 stores `wr_data_i` (word 0 in bits 31:0) as line `wr_line_i`. Bit 0 of the line number selects the even or odd bank. Fetches after the write edge return the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| redirect_i | input | 1 | Flush queue and load new fetch address |
| redirect_pc_i | input | PC_W | New byte fetch address |
| wr_en_i | input | 1 | Line write strobe for the backing store |
| wr_line_i | input | log2(LINES) | Line number written |
| wr_data_i | input | 128 | Line data, word 0 in the low bits |
| out_valid_o | output | 1 | Head group available |
| out_ready_i | input | 1 | Consumer accepts head group |
| out_pc_o | output | PC_W | Byte address of the head group's first word |
| out_words_o | output | 128 | Four words, lane 0 in the low bits |
| err_o | output | 1 | Fetch pointer misaligned, fetching halted |

## Verification
A wrong bank index or rotate amount appears in the first group fetched from an offending address. It shows as a swapped or repeated lane one cycle after the redirect that reaches it. The bench walks every word offset and the wrap from the last line to line 0 to expose this. Queue pointer or occupancy faults show up after a stall, once the consumer resumes. The head address then skips or repeats 16-byte steps within the next few accepted groups, or `out_valid_o` drops while the pointer is aligned. A lost flush or misalignment flag shows the cycle after the redirect, as a stale group or a wrong `err_o`.

// File: rtl/wf_pkg.sv
package wf_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned GROUP_N = 4;
  localparam int unsigned GROUP_W = WORD_W * GROUP_N;
  localparam int unsigned ROT_W   = $clog2(GROUP_N);
  typedef logic [GROUP_W-1:0] group_t;
endpackage

// File: rtl/wf_line_bank.sv
module wf_line_bank #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 128,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/wf_rotate.sv
module wf_rotate
  import wf_pkg::*;
(
  input  group_t           lo_i,
  input  group_t           hi_i,
  input  logic [ROT_W-1:0] rot_i,
  output group_t           words_o
);
  logic [2*GROUP_W-1:0] pair;
  assign pair = {hi_i, lo_i};

  for (genvar k = 0; k < GROUP_N; k++) begin : g_lane
    logic [ROT_W:0] sel;
    assign sel = {1'b0, rot_i} + (ROT_W+1)'(k);
    assign words_o[k*WORD_W +: WORD_W] = pair[int'(sel)*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/wf_group_fifo.sv
module wf_group_fifo #(
  parameter int unsigned DATA_W = 160,
  parameter int unsigned DEPTH  = 2,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              pop_i,
  output logic              full_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] dout_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  count_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      if (push_i && !pop_i)      count_q <= count_q + 1'b1;
      else if (pop_i && !push_i) count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_ptr_q] <= din_i;
  end

  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign valid_o = (count_q != '0);
  assign dout_o  = mem_q[rd_ptr_q];
endmodule

// File: rtl/wide_fetch_unit.sv
module wide_fetch_unit
  import wf_pkg::*;
#(
  parameter int unsigned LINES      = 16,
  parameter int unsigned PC_W       = 32,
  parameter int unsigned Q_DEPTH    = 2,
  parameter logic [31:0] RESET_PC   = 32'h0,
  localparam int unsigned LINE_BITS = $clog2(LINES),
  localparam int unsigned BANK_D    = LINES / 2,
  localparam int unsigned BIDX_W    = (LINE_BITS > 1) ? LINE_BITS - 1 : 1,
  localparam int unsigned ENTRY_W   = PC_W + GROUP_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 redirect_i,
  input  logic [PC_W-1:0]      redirect_pc_i,
  input  logic                 wr_en_i,
  input  logic [LINE_BITS-1:0] wr_line_i,
  input  logic [GROUP_W-1:0]   wr_data_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [PC_W-1:0]      out_pc_o,
  output logic [GROUP_W-1:0]   out_words_o,
  output logic                 err_o
);
  logic [PC_W-1:0]      pc_q;
  logic [LINE_BITS-1:0] line;
  logic [ROT_W-1:0]     rot;
  logic                 misaligned;
  logic [BIDX_W-1:0]    bank_ra [2];
  group_t               bank_rd [2];
  group_t               lo_line, hi_line, group_words;
  logic                 q_full, q_valid, push, pop;
  logic [ENTRY_W-1:0]   q_dout;

  assign line       = pc_q[4 +: LINE_BITS];
  assign rot        = pc_q[2 +: ROT_W];
  assign misaligned = |pc_q[1:0];

  // odd bank always holds line L or L+1 at index L>>1; even bank steps up when L is odd
  assign bank_ra[1] = line[LINE_BITS-1:1];
  assign bank_ra[0] = line[LINE_BITS-1:1] + BIDX_W'(line[0]);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    wf_line_bank #(.DEPTH(BANK_D), .DATA_W(GROUP_W)) u_bank (
      .clk_i   (clk_i),
      .we_i    (wr_en_i && (wr_line_i[0] == 1'(b))),
      .waddr_i (wr_line_i[LINE_BITS-1:1]),
      .wdata_i (wr_data_i),
      .raddr_i (bank_ra[b]),
      .rdata_o (bank_rd[b])
    );
  end

  assign lo_line = line[0] ? bank_rd[1] : bank_rd[0];
  assign hi_line = line[0] ? bank_rd[0] : bank_rd[1];

  wf_rotate u_rot (
    .lo_i    (lo_line),
    .hi_i    (hi_line),
    .rot_i   (rot),
    .words_o (group_words)
  );

  assign pop  = q_valid && out_ready_i && !redirect_i;
  assign push = !misaligned && !redirect_i && (!q_full || pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pc_q <= PC_W'(RESET_PC);
    else if (redirect_i) pc_q <= redirect_pc_i;
    else if (push)       pc_q <= pc_q + PC_W'(16);
  end

  wf_group_fifo #(.DATA_W(ENTRY_W), .DEPTH(Q_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (redirect_i),
    .push_i  (push),
    .din_i   ({pc_q, group_words}),
    .pop_i   (pop),
    .full_o  (q_full),
    .valid_o (q_valid),
    .dout_o  (q_dout)
  );

  assign out_valid_o = q_valid;
  assign out_pc_o    = q_dout[GROUP_W +: PC_W];
  assign out_words_o = q_dout[GROUP_W-1:0];
  assign err_o       = misaligned;
endmodule

// File: rtl/wf_checker.sv
module wf_checker #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned GROUP_W = 128
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               redirect_i,
  input logic               out_ready_i,
  input logic               out_valid_o,
  input logic [PC_W-1:0]    out_pc_o,
  input logic [GROUP_W-1:0] out_words_o,
  input logic               err_o
);
  a_r4_no_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !redirect_i && !err_o) |=> out_valid_o);

  a_r5_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !redirect_i)
      |=> (!out_valid_o || out_pc_o == $past(out_pc_o) + PC_W'(16)));

  a_r6_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !redirect_i)
      |=> (out_valid_o && $stable(out_pc_o) && $stable(out_words_o)));

  a_r7_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> !out_valid_o);

  a_r8_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !out_valid_o);

  always_comb begin
    if (!rst_ni) a_r1_reset_idle: assert (!out_valid_o);
  end
endmodule

bind wide_fetch_unit wf_checker #(.PC_W(PC_W), .GROUP_W(wf_pkg::GROUP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .redirect_i  (redirect_i),
  .out_ready_i (out_ready_i),
  .out_valid_o (out_valid_o),
  .out_pc_o    (out_pc_o),
  .out_words_o (out_words_o),
  .err_o       (err_o)
);

// File: tb/wide_fetch_unit_tb.sv
module wide_fetch_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 16;
  localparam int NWORDS = LINES * 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         redirect_i = 1'b0;
  logic [31:0]  redirect_pc_i = '0;
  logic         wr_en_i = 1'b0;
  logic [3:0]   wr_line_i = '0;
  logic [127:0] wr_data_i = '0;
  logic         out_valid_o, out_ready_i = 1'b0, err_o;
  logic [31:0]  out_pc_o;
  logic [127:0] out_words_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] model [NWORDS];

  // {pc, index of first expected word}
  localparam logic [39:0] VEC [8] = '{
    {32'h0000_0000, 8'd0},  {32'h0000_0004, 8'd1},
    {32'h0000_000C, 8'd3},  {32'h0000_0038, 8'd14},
    {32'h0000_00F8, 8'd62}, {32'h0000_00FC, 8'd63},
    {32'h0000_0100, 8'd0},  {32'h0000_1234, 8'd13}
  };

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wide_fetch_unit #(.LINES(LINES)) u_dut (
    .clk_i, .rst_ni, .redirect_i, .redirect_pc_i, .wr_en_i, .wr_line_i,
    .wr_data_i, .out_valid_o, .out_ready_i, .out_pc_o, .out_words_o, .err_o
  );

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] grp(input int n);
    logic [127:0] g;
    for (int k = 0; k < 4; k++) g[k*32 +: 32] = model[(n + k) % NWORDS];
    return g;
  endfunction

  task automatic write_line(input int l);
    wr_en_i = 1'b1; wr_line_i = 4'(l); wr_data_i = grp(l * 4);
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic redirect(input logic [31:0] pc);
    redirect_i = 1'b1; redirect_pc_i = pc;
    step();
    redirect_i = 1'b0;
  endtask

  initial begin
    for (int n = 0; n < NWORDS; n++) model[n] = 32'hC0DE_0000 + 32'(n);
    for (int l = 0; l < LINES; l++) write_line(l);
    check("R1 valid in reset", 128'(out_valid_o), 128'd0);
    rst_ni = 1'b1;
    check("R1 valid after release", 128'(out_valid_o), 128'd0);
    check("R1 err after release", 128'(err_o), 128'd0);
    step();
    check("R1 first valid", 128'(out_valid_o), 128'd1);
    check("R1 first pc", 128'(out_pc_o), 128'd0);
    check("R2 first words", out_words_o, grp(0));

    for (int i = 0; i < 8; i++) begin
      redirect(VEC[i][39:8]);
      check("R7 flushed", 128'(out_valid_o), 128'd0);
      step();
      check("R7 new group valid", 128'(out_valid_o), 128'd1);
      check("R5 group pc", 128'(out_pc_o), 128'(VEC[i][39:8]));
      check("R3 merged words", out_words_o, grp(int'(VEC[i][7:0])));
    end

    // stall with full queue, then stream
    step(); step(); step();
    check("R6 stalled head", 128'(out_pc_o), 128'h1234);
    out_ready_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      check("R4 streaming valid", 128'(out_valid_o), 128'd1);
      check("R6 in-order pc", 128'(out_pc_o), 128'(32'h1234 + 32'(16 * i)));
      check("R2 streaming words", out_words_o, grp(13 + 4 * i));
      step();
    end
    out_ready_i = 1'b0;

    redirect(32'h22);
    check("R8 err raised", 128'(err_o), 128'd1);
    step(); step(); step();
    check("R8 no push", 128'(out_valid_o), 128'd0);
    check("R8 err held", 128'(err_o), 128'd1);
    redirect(32'h40);
    check("R8 err cleared", 128'(err_o), 128'd0);
    step();
    check("R8 resume pc", 128'(out_pc_o), 128'h40);
    check("R8 resume words", out_words_o, grp(16));

    for (int n = 20; n < 28; n++) model[n] = 32'hBEEF_0000 + 32'(n);
    write_line(5);
    write_line(6);
    redirect(32'h5C);
    step();
    check("R9 rewritten lines", out_words_o, grp(23));

    out_ready_i = 1'b1;
    redirect(32'h80);
    check("R7 flush while ready", 128'(out_valid_o), 128'd0);
    step();
    check("R7 redirect pc", 128'(out_pc_o), 128'h80);
    step();
    check("R5 next pc", 128'(out_pc_o), 128'h90);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk_i);
    #2;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule